// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block is the sequencing state machine of an SRAM whose every cell has a nonvolatile shadow. It decides when the whole array is copied into the shadow (a store) or copied back (a recall). It hands each copy to an external array engine through single-cycle start strobes and waits for that engine's done pulse. While a copy runs, and whenever the supply is not good, it closes the SRAM to ordinary reads and writes. The engine itself, the analog supply sensing and the array are outside this block.

A store has three sources. The first is a falling edge on an active-low hardware request pin. The second is a software store command. The third is the power-good flag falling while the automatic store is armed. A dirty flag records whether any write was accepted since the last completed copy. The hardware and power-loss sources are skipped when that flag is clear, but the software source always runs. A hardware request opens a short grace window before the store begins: reads stay open during the window, while new writes are refused for as long as the pin is held low. When power-good returns, a two-phase recall runs: first the engine clears the array, then it transfers the shadow. The arm bit for the automatic store has a working copy, which software changes. A completed store saves that copy to a persistent bit, and a completed recall reloads it from there.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy_n_o` is 1, `rd_block_o` and `wr_block_o` are 1, `auto_arm_o` is 1 and no start strobe is asserted. The persistent arm bit also resets to 1.
- R2: From the off state, once synchronized power-good is high, `recall_clr_go_o` pulses. After the engine's done, `recall_xfer_go_o` pulses. Both blocks stay at 1 until the transfer's done; if power is good, they drop to 0 in the cycle after that done.
- R3: `sw_cmd_code_i` encodes store=0, recall=1, disarm=2 and arm=3. The command is taken only in the idle state. A software store runs even when no write has occurred.
- R4: The dirty flag is set by a write that is accepted (`sram_wr_i` high while `wr_block_o` is 0). It is cleared when a store or a recall completes. When it is clear, a hardware request does not start a store.
- R5: A hardware request that arrives while dirty enters a grace window of `GRACE_CYC` cycles, during which `rd_block_o` stays 0. `store_go_o` then rises `SYNC_STAGES + GRACE_CYC + 1` cycles after the pin falls.
- R6: `wr_block_o` is 1 whenever the synchronized hardware request is low. A write attempted then is not accepted.
- R7: `busy_n_o` is 0 from the cycle in which `store_go_o` pulses until the engine's done. It is 1 again in the cycle after that done, and it is 1 at all other times.
- R8: `rd_block_o` and `wr_block_o` are 1 during any store or recall, and in any cycle in which `pwr_ok_i` is 0.
- R9: If synchronized power-good falls while idle, a store starts when the block is armed and dirty; otherwise no store runs. In either case the block then waits in the off state for power-good.
- R10: Disarm and arm commands change `auto_arm_o`. A completed store copies `auto_arm_o` into the persistent bit, and a completed recall loads `auto_arm_o` from it.
- R11: Requests that arrive during a grace window, a store or a recall are dropped, not queued. A hardware request that is held low starts at most one store.
- R12: Each start strobe lasts one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (factory state) |
| pwr_ok_i | input | 1 | Supply comparator: 1 while the supply is above the switch level |
| hw_req_n_i | input | 1 | Active-low hardware store request pin |
| sw_cmd_vld_i | input | 1 | One-cycle software command pulse |
| sw_cmd_code_i | input | 2 | Software command code (see R3) |
| sram_wr_i | input | 1 | Observed SRAM write strobe |
| eng_done_i | input | 1 | One-cycle completion pulse from the array copy engine |
| busy_n_o | output | 1 | Open-drain-style busy, 0 while a store runs |
| rd_block_o | output | 1 | Inhibit for SRAM reads |
| wr_block_o | output | 1 | Inhibit for SRAM writes |
| store_go_o | output | 1 | Start strobe: copy array to shadow |
| recall_clr_go_o | output | 1 | Start strobe: clear array (recall phase one) |
| recall_xfer_go_o | output | 1 | Start strobe: copy shadow to array (recall phase two) |
| auto_arm_o | output | 1 | Working arm bit of the power-loss store |

## Verification
The bench times the hardware path to the exact cycle of the store strobe. A design with a wrong grace count or a missing synchronizer stage would fire early or late there. It attempts a write while the request is held low, then releases the request and pulses it again. A design that accepted that write would run a store that should never happen. It also issues a recall command and a second request edge while a store is in flight; a design that queued requests would start a second copy afterwards. Finally, it power-cycles the block after disarming, both with and without a manual store. A design that reset the working arm bit instead of reloading the persistent one, or that saved it at any time other than store completion, would show the wrong arm state after the recall.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_RCL_CLR  = 3'd1,
        ST_RCL_XFER = 3'd2,
        ST_IDLE     = 3'd3,
        ST_GRACE    = 3'd4,
        ST_STORE    = 3'd5
    } nv_state_e;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_STORE   = 2'd0,
        CMD_RECALL  = 2'd1,
        CMD_ARM_OFF = 2'd2,
        CMD_ARM_ON  = 2'd3
    } nv_cmd_e;

    // Start strobes towards the array copy engine
    typedef struct packed {
        logic store;
        logic rcl_clr;
        logic rcl_xfer;
    } nv_go_t;

    // Single-cycle events that update the flag register
    typedef struct packed {
        logic store_fin;
        logic recall_fin;
        logic arm_set;
        logic arm_clr;
    } nv_evt_t;

    // States in which the SRAM port is open to reads
    function automatic logic port_open(nv_state_e s);
        return (s == ST_IDLE) || (s == ST_GRACE);
    endfunction

    // Where an operation lands when it finishes
    function automatic nv_state_e after_op(logic pwr);
        return pwr ? ST_IDLE : ST_OFF;
    endfunction

endpackage

// File: rtl/nvsc_sync.sv
module nvsc_sync #(
    parameter int            W       = 2,
    parameter int            N       = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[N-1];
endmodule

// File: rtl/nvsc_grace.sv
module nvsc_grace #(
    parameter int GRACE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int          CW   = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/nvsc_flags.sv
module nvsc_flags
    import nvsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_acc,
    input  nv_evt_t evt,
    output logic    dirty,
    output logic    auto_en
);
    logic nv_auto;

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty   <= 1'b0;
            auto_en <= 1'b1;
            nv_auto <= 1'b1;
        end else begin
            if (evt.store_fin || evt.recall_fin) begin
                dirty <= 1'b0;
            end else if (wr_acc) begin
                dirty <= 1'b1;
            end

            if (evt.store_fin) begin
                nv_auto <= auto_en;
            end

            if (evt.recall_fin) begin
                auto_en <= nv_auto;
            end else if (evt.arm_set) begin
                auto_en <= 1'b1;
            end else if (evt.arm_clr) begin
                auto_en <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nvsc_fsm.sv
module nvsc_fsm
    import nvsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_s,
    input  logic      hw_n_s,
    input  logic      sw_vld,
    input  nv_cmd_e   sw_code,
    input  logic      dirty,
    input  logic      auto_en,
    input  logic      grace_done,
    input  logic      eng_done,
    output nv_state_e state,
    output nv_go_t    go,
    output nv_evt_t   evt,
    output logic      busy_n
);
    nv_state_e nxt;
    logic      hw_prev;
    logic      hw_fall;

    assign hw_fall = hw_prev & ~hw_n_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (pwr_s) nxt = ST_RCL_CLR;
            end
            ST_RCL_CLR: begin
                if (eng_done) nxt = ST_RCL_XFER;
            end
            ST_RCL_XFER: begin
                if (eng_done) nxt = after_op(pwr_s);
            end
            ST_IDLE: begin
                if (!pwr_s) begin
                    nxt = (auto_en && dirty) ? ST_STORE : ST_OFF;
                end else if (hw_fall && dirty) begin
                    nxt = ST_GRACE;
                end else if (sw_vld && sw_code == CMD_STORE) begin
                    nxt = ST_STORE;
                end else if (sw_vld && sw_code == CMD_RECALL) begin
                    nxt = ST_RCL_CLR;
                end
            end
            ST_GRACE: begin
                if (grace_done || !pwr_s) nxt = ST_STORE;
            end
            ST_STORE: begin
                if (eng_done) nxt = after_op(pwr_s);
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        evt.store_fin  = (state == ST_STORE) && eng_done;
        evt.recall_fin = (state == ST_RCL_XFER) && eng_done;
        evt.arm_set    = (state == ST_IDLE) && (nxt == ST_IDLE) && sw_vld
                         && (sw_code == CMD_ARM_ON);
        evt.arm_clr    = (state == ST_IDLE) && (nxt == ST_IDLE) && sw_vld
                         && (sw_code == CMD_ARM_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            hw_prev <= 1'b1;
            go      <= '0;
            busy_n  <= 1'b1;
        end else begin
            state       <= nxt;
            hw_prev     <= hw_n_s;
            go.store    <= (nxt == ST_STORE) && (state != ST_STORE);
            go.rcl_clr  <= (nxt == ST_RCL_CLR) && (state != ST_RCL_CLR);
            go.rcl_xfer <= (nxt == ST_RCL_XFER) && (state != ST_RCL_XFER);
            busy_n      <= (nxt != ST_STORE);
        end
    end
endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl
    import nvsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GRACE_CYC   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_ok_i,
    input  logic                hw_req_n_i,
    input  logic                sw_cmd_vld_i,
    input  logic [CMD_W-1:0]    sw_cmd_code_i,
    input  logic                sram_wr_i,
    input  logic                eng_done_i,
    output logic                busy_n_o,
    output logic                rd_block_o,
    output logic                wr_block_o,
    output logic                store_go_o,
    output logic                recall_clr_go_o,
    output logic                recall_xfer_go_o,
    output logic                auto_arm_o
);
    localparam int          SYNC_W   = 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = 2'b10; // request idles high, power starts low

    logic [SYNC_W-1:0] sync_q;
    logic              pwr_s;
    logic              hw_n_s;
    nv_state_e         state;
    nv_go_t            go;
    nv_evt_t           evt;
    logic              dirty;
    logic              grace_done;
    logic              wr_acc;

    nvsc_sync #(
        .W       (SYNC_W),
        .N       (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hw_req_n_i, pwr_ok_i}),
        .q   (sync_q)
    );

    assign pwr_s  = sync_q[0];
    assign hw_n_s = sync_q[1];

    nvsc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_s      (pwr_s),
        .hw_n_s     (hw_n_s),
        .sw_vld     (sw_cmd_vld_i),
        .sw_code    (nv_cmd_e'(sw_cmd_code_i)),
        .dirty      (dirty),
        .auto_en    (auto_arm_o),
        .grace_done (grace_done),
        .eng_done   (eng_done_i),
        .state      (state),
        .go         (go),
        .evt        (evt),
        .busy_n     (busy_n_o)
    );

    nvsc_grace #(
        .GRACE_CYC (GRACE_CYC)
    ) u_grace (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_GRACE),
        .done (grace_done)
    );

    assign rd_block_o = !pwr_ok_i || !pwr_s || !port_open(state);
    assign wr_block_o = rd_block_o || !hw_n_s || (state == ST_GRACE);
    assign wr_acc     = sram_wr_i && !wr_block_o;

    nvsc_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (wr_acc),
        .evt     (evt),
        .dirty   (dirty),
        .auto_en (auto_arm_o)
    );

    assign store_go_o       = go.store;
    assign recall_clr_go_o  = go.rcl_clr;
    assign recall_xfer_go_o = go.rcl_xfer;
endmodule

// File: rtl/nvsc_chk.sv
module nvsc_chk (
    input logic clk,
    input logic rst,
    input logic pwr_ok_i,
    input logic eng_done_i,
    input logic busy_n_o,
    input logic rd_block_o,
    input logic wr_block_o,
    input logic store_go_o,
    input logic recall_clr_go_o,
    input logic recall_xfer_go_o,
    input logic auto_arm_o,
    input logic hw_n_s
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (busy_n_o && rd_block_o && wr_block_o && auto_arm_o
                 && !store_go_o && !recall_clr_go_o && !recall_xfer_go_o));

    // R12
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_go_o, recall_clr_go_o, recall_xfer_go_o}));

    // R12
    store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        store_go_o |=> !store_go_o);

    // R12
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        recall_clr_go_o |=> !recall_clr_go_o);

    // R12
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        recall_xfer_go_o |=> !recall_xfer_go_o);

    // R7
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        store_go_o |-> !busy_n_o);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_n_o && eng_done_i) |=> busy_n_o);

    // R8
    pwr_block_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok_i |-> (rd_block_o && wr_block_o));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_n_o |-> (rd_block_o && wr_block_o));

    // R6
    hw_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        !hw_n_s |-> wr_block_o);
endmodule

bind nv_shadow_ctrl nvsc_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .pwr_ok_i         (pwr_ok_i),
    .eng_done_i       (eng_done_i),
    .busy_n_o         (busy_n_o),
    .rd_block_o       (rd_block_o),
    .wr_block_o       (wr_block_o),
    .store_go_o       (store_go_o),
    .recall_clr_go_o  (recall_clr_go_o),
    .recall_xfer_go_o (recall_xfer_go_o),
    .auto_arm_o       (auto_arm_o),
    .hw_n_s           (hw_n_s)
);

// File: tb/nv_shadow_ctrl_bench.sv
module nv_shadow_ctrl_bench;
    localparam int GRACE   = 8;
    localparam int STAGES  = 2;
    localparam int ENG_LAT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_ok_i = 1'b0;
    logic       hw_req_n_i = 1'b1;
    logic       sw_cmd_vld_i = 1'b0;
    logic [1:0] sw_cmd_code_i = 2'd0;
    logic       sram_wr_i = 1'b0;
    logic       eng_done_i = 1'b0;
    logic       busy_n_o, rd_block_o, wr_block_o;
    logic       store_go_o, recall_clr_go_o, recall_xfer_go_o, auto_arm_o;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_st = 0;
    int cnt_clr = 0;
    int cnt_xf = 0;

    always #10 clk = ~clk;

    nv_shadow_ctrl #(
        .SYNC_STAGES (STAGES),
        .GRACE_CYC   (GRACE)
    ) u_nv_shadow_ctrl (
        .clk              (clk),
        .rst              (rst),
        .pwr_ok_i         (pwr_ok_i),
        .hw_req_n_i       (hw_req_n_i),
        .sw_cmd_vld_i     (sw_cmd_vld_i),
        .sw_cmd_code_i    (sw_cmd_code_i),
        .sram_wr_i        (sram_wr_i),
        .eng_done_i       (eng_done_i),
        .busy_n_o         (busy_n_o),
        .rd_block_o       (rd_block_o),
        .wr_block_o       (wr_block_o),
        .store_go_o       (store_go_o),
        .recall_clr_go_o  (recall_clr_go_o),
        .recall_xfer_go_o (recall_xfer_go_o),
        .auto_arm_o       (auto_arm_o)
    );

    task automatic chk_eq(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw(input logic [1:0] code);
        @(negedge clk);
        sw_cmd_vld_i  = 1'b1;
        sw_cmd_code_i = code;
        @(negedge clk);
        sw_cmd_vld_i  = 1'b0;
    endtask

    task automatic wr1();
        @(negedge clk);
        sram_wr_i = 1'b1;
        @(negedge clk);
        sram_wr_i = 1'b0;
    endtask

    task automatic settle();
        int n = 0;
        while ((rd_block_o || !busy_n_o || eng_done_i) && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk_eq("R2 block returns to open state", int'(rd_block_o), 0);
        cyc(2);
    endtask

    // Array copy engine model: answers every start strobe after ENG_LAT cycles
    initial begin : engine
        int pend = 0;
        int kind = 0;
        forever begin
            @(negedge clk);
            if (eng_done_i) begin
                eng_done_i = 1'b0;
                if (kind == 1) chk_eq("R7 busy high one cycle after done", int'(busy_n_o), 1);
                if (kind == 3) chk_eq("R2 access open after transfer done", int'(rd_block_o), int'(!pwr_ok_i));
            end
            if (store_go_o) begin
                cnt_st++;
                kind = 1;
                pend = ENG_LAT;
                chk_eq("R7 busy low with store strobe", int'(busy_n_o), 0);
            end else if (recall_clr_go_o) begin
                cnt_clr++;
                kind = 2;
                pend = ENG_LAT;
            end else if (recall_xfer_go_o) begin
                chk_eq("R2 transfer follows clear", cnt_clr, cnt_xf + 1);
                cnt_xf++;
                kind = 3;
                pend = ENG_LAT;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    eng_done_i = 1'b1;
                    if (kind == 1) chk_eq("R7 busy low until done", int'(busy_n_o), 0);
                    chk_eq("R8 writes blocked during copy", int'(wr_block_o), 1);
                    if (kind >= 2) chk_eq("R8 reads blocked during recall", int'(rd_block_o), 1);
                end
            end
        end
    end

    task automatic t_reset();
        cyc(3);
        chk_eq("R1 busy idle in reset", int'(busy_n_o), 1);
        chk_eq("R1 reads blocked in reset", int'(rd_block_o), 1);
        chk_eq("R1 writes blocked in reset", int'(wr_block_o), 1);
        chk_eq("R1 no strobe in reset", int'(store_go_o | recall_clr_go_o | recall_xfer_go_o), 0);
        chk_eq("R1 armed after reset", int'(auto_arm_o), 1);
        rst = 1'b0;
        cyc(10);
        chk_eq("R2 no recall without power-good", cnt_clr, 0);
        chk_eq("R2 blocked without power-good", int'(rd_block_o), 1);
    endtask

    task automatic t_powerup();
        pwr_ok_i = 1'b1;
        settle();
        chk_eq("R2 one clear phase", cnt_clr, 1);
        chk_eq("R2 one transfer phase", cnt_xf, 1);
        chk_eq("R2 no store at power-up", cnt_st, 0);
        chk_eq("R2 writes open after recall", int'(wr_block_o), 0);
    endtask

    task automatic t_sw_store_clean();
        int s0 = cnt_st;
        sw(2'd0);
        cyc(1);
        chk_eq("R8 writes blocked during store", int'(wr_block_o), 1);
        settle();
        chk_eq("R3 software store runs while clean", cnt_st, s0 + 1);
    endtask

    task automatic t_hw_clean();
        int s0 = cnt_st;
        @(negedge clk) hw_req_n_i = 1'b0;
        cyc(3);
        chk_eq("R6 writes blocked while request low", int'(wr_block_o), 1);
        chk_eq("R6 reads open while request low", int'(rd_block_o), 0);
        wr1();
        cyc(30);
        chk_eq("R4 clean hardware request skipped", cnt_st, s0);
        chk_eq("R4 busy stays high when skipped", int'(busy_n_o), 1);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
        chk_eq("R6 writes open after release", int'(wr_block_o), 0);
        @(negedge clk) hw_req_n_i = 1'b0;
        cyc(30);
        chk_eq("R6 write during held request not accepted", cnt_st, s0);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
    endtask

    task automatic t_hw_grace();
        int s0;
        int n = 0;
        int rd_seen = 0;
        wr1();
        cyc(2);
        s0 = cnt_st;
        @(negedge clk) hw_req_n_i = 1'b0;
        while (!store_go_o && n < 60) begin
            @(negedge clk);
            n++;
            if (n == GRACE + 1) rd_seen = int'(rd_block_o);
        end
        chk_eq("R5 store strobe cycle after pin falls", n, STAGES + GRACE + 1);
        chk_eq("R5 reads open inside grace window", rd_seen, 0);
        settle();
        cyc(20);
        chk_eq("R11 held request starts one store", cnt_st, s0 + 1);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
        @(negedge clk) hw_req_n_i = 1'b0;
        cyc(30);
        chk_eq("R4 dirty cleared by store completion", cnt_st, s0 + 1);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
    endtask

    task automatic t_ignore_busy();
        int s0 = cnt_st;
        int c0 = cnt_clr;
        wr1();
        sw(2'd0);
        cyc(1);
        sw(2'd1);
        @(negedge clk) hw_req_n_i = 1'b0;
        settle();
        cyc(20);
        chk_eq("R11 no queued store", cnt_st, s0 + 1);
        chk_eq("R11 no queued recall", cnt_clr, c0);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
    endtask

    task automatic t_sw_recall();
        int s0 = cnt_st;
        int c0 = cnt_clr;
        int x0 = cnt_xf;
        wr1();
        sw(2'd1);
        settle();
        chk_eq("R3 software recall clear phase", cnt_clr, c0 + 1);
        chk_eq("R3 software recall transfer phase", cnt_xf, x0 + 1);
        @(negedge clk) hw_req_n_i = 1'b0;
        cyc(30);
        chk_eq("R4 dirty cleared by recall completion", cnt_st, s0);
        @(negedge clk) hw_req_n_i = 1'b1;
        cyc(3);
    endtask

    task automatic t_power_loss();
        int s0;
        int c0;
        int n = 0;
        wr1();
        s0 = cnt_st;
        c0 = cnt_clr;
        @(negedge clk) pwr_ok_i = 1'b0;
        @(negedge clk);
        chk_eq("R8 reads blocked when power drops", int'(rd_block_o), 1);
        chk_eq("R8 writes blocked when power drops", int'(wr_block_o), 1);
        while (!store_go_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        cyc(30);
        chk_eq("R9 armed dirty power loss stores", cnt_st, s0 + 1);
        chk_eq("R9 waits for power after store", cnt_clr, c0);
        chk_eq("R9 stays blocked while off", int'(rd_block_o), 1);
        pwr_ok_i = 1'b1;
        settle();
        chk_eq("R2 recall after power returns", cnt_clr, c0 + 1);
    endtask

    task automatic t_power_loss_clean();
        int s0 = cnt_st;
        @(negedge clk) pwr_ok_i = 1'b0;
        cyc(30);
        chk_eq("R9 clean power loss skipped", cnt_st, s0);
        pwr_ok_i = 1'b1;
        settle();
    endtask

    task automatic t_disarmed();
        int s0;
        sw(2'd2);
        chk_eq("R10 disarm command", int'(auto_arm_o), 0);
        wr1();
        s0 = cnt_st;
        @(negedge clk) pwr_ok_i = 1'b0;
        cyc(30);
        chk_eq("R9 disarmed power loss skipped", cnt_st, s0);
        pwr_ok_i = 1'b1;
        settle();
        chk_eq("R10 recall reloads persistent arm bit", int'(auto_arm_o), 1);
    endtask

    task automatic t_arm_persist();
        sw(2'd2);
        sw(2'd0);
        settle();
        @(negedge clk) pwr_ok_i = 1'b0;
        cyc(20);
        pwr_ok_i = 1'b1;
        settle();
        chk_eq("R10 saved disarm survives power cycle", int'(auto_arm_o), 0);
        sw(2'd3);
        chk_eq("R10 arm command", int'(auto_arm_o), 1);
        sw(2'd0);
        settle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_powerup();
        t_sw_store_clean();
        t_hw_clean();
        t_hw_grace();
        t_ignore_busy();
        t_sw_recall();
        t_power_loss();
        t_power_loss_clean();
        t_disarmed();
        t_arm_persist();
        cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule